// File: doc/BRIEF.md
# Host DMA Request Generator

This block raises a DMA request line toward an external DMA controller when the on-chip CPU has work for the host. The CPU sets a trigger bit through a small register port. The request then stays active until the external host completes a read or write of the data register that the host's index pointer selects. Other host activity leaves the request untouched. This includes a write to the index pointer itself, a data access at another index, and strobes issued without chip select.

The host lines are asynchronous to the block clock. Each one passes through a two-stage synchronizer. The block acts on the end of a host access, which is the falling edge of the synchronized "chip selected and a strobe low" condition. The register-select level and index value seen during the access are latched while the access is in progress. The request is cleared on the same edge as the trigger bit, so software always reads a pending flag that agrees with the pin. The asserted level of the pin is programmable, and one mode value is reserved and keeps the pin inactive.

Top module: `hdrq_top`

## Requirements
- R1: After reset the polarity, mode and pending bits are 0, the target index is 0, and `dreq_pin` is 1.
- R2: With mode 0, a CPU write to address 1 with bit 0 set makes the request pending and drives `dreq_pin` to its asserted level. That level equals the polarity bit: 0 for active-low, 1 for active-high. The pin changes on the same clock edge as the write.
- R3: A write of 0 to bit 0 of address 1 has no effect. A write of 1 while a request is pending keeps it asserted and queues nothing, so one qualifying host access returns the pin to its inactive level, and it stays there.
- R4: A qualifying host access clears the pending bit and sets `dreq_pin` to its inactive level (the inverse of the polarity bit). A qualifying access has chip select low, `host_rs`=1, either strobe low, and `host_idx` equal to the target index, with the data lines stable during the access. Both changes happen on the third rising edge after the strobe is released. This is inside the five-cycle limit.
- R5: A host access with `host_rs`=0, which targets the index register, never clears a pending request.
- R6: A data access with a non-matching index does not clear a pending request. Neither does a strobe with chip select high.
- R7: Bit 0 of address 0 is the polarity bit. Any control write with it set clears the pending bit and drives `dreq_pin` low on that edge. Later triggers then drive the pin high.
- R8: Bit 1 of address 0 is the mode bit. With mode 1 (reserved), the pending bit is cleared, triggers are ignored, and `dreq_pin` holds its inactive level.
- R9: `cpu_rdata` reflects `cpu_addr` combinationally. Address 0 returns {mode, polarity} in bits 1:0, address 1 returns the pending bit in bit 0, address 2 returns the target index, address 3 returns 0, and all unused bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_addr | input | 2 | CPU register address |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | CPU read data |
| host_cs_n | input | 1 | Host chip select, active low, asynchronous |
| host_rs | input | 1 | Host register select: 0 index register, 1 data register |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_idx | input | IDXW | Current host index pointer value |
| dreq_pin | output | 1 | DMA request to the external controller |

## Verification
The pending bit and the pin always move together. A corrupted pending flag therefore shows as a wrong `dreq_pin` level at the next sample after the edge that caused it, and as a mismatch between the pin and bit 0 of address 1. An error in the synchronizer depth or the edge detector shows as the pin negating one cycle early or late relative to strobe release, which the bench checks on both sides of the expected edge. A detector that latches register select or the index wrongly shows as a pin that index writes or mismatched accesses release. It can also show as a pin that stays asserted after a qualifying access, visible within three cycles of the strobe release.

// File: rtl/hdrq_pkg.sv
package hdrq_pkg;

    localparam int CPU_AW = 2;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_TRIG = 2'd1,
        REG_TGT  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        MODE_ACCESS = 1'b0,
        MODE_RSVD   = 1'b1
    } neg_mode_e;

    // bit 1 mode, bit 0 polarity
    typedef struct packed {
        neg_mode_e mode;
        logic      pol;
    } ctrl_t;

    // summary of one finished host access
    typedef struct packed {
        logic done;
        logic data_reg;
        logic idx_match;
    } host_evt_t;

    function automatic logic idle_level(input logic pol);
        return ~pol;
    endfunction

    function automatic logic pin_level(input logic pend, input ctrl_t c);
        return (pend && c.mode == MODE_ACCESS) ? c.pol : idle_level(c.pol);
    endfunction

endpackage

// File: rtl/hdrq_sync.sv
module hdrq_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hdrq_host_det.sv
module hdrq_host_det
    import hdrq_pkg::*;
#(
    parameter int IDXW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n_s,
    input  logic            rs_s,
    input  logic            rd_n_s,
    input  logic            wr_n_s,
    input  logic [IDXW-1:0] idx_s,
    input  logic [IDXW-1:0] tgt_idx,
    output host_evt_t       evt
);
    logic            act;
    logic            act_d;
    logic            cap_rs;
    logic [IDXW-1:0] cap_idx;

    assign act = ~cs_n_s & (~rd_n_s | ~wr_n_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_d   <= 1'b0;
            cap_rs  <= 1'b0;
            cap_idx <= '0;
        end else begin
            act_d <= act;
            if (act) begin
                cap_rs  <= rs_s;
                cap_idx <= idx_s;
            end
        end
    end

    always_comb begin
        evt.done      = act_d & ~act;
        evt.data_reg  = cap_rs;
        evt.idx_match = (cap_idx == tgt_idx);
    end
endmodule

// File: rtl/hdrq_core.sv
module hdrq_core
    import hdrq_pkg::*;
#(
    parameter int DW   = 8,
    parameter int IDXW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [DW-1:0]     cpu_rdata,
    input  host_evt_t         evt,
    output ctrl_t             ctrl_q,
    output logic              pend_q,
    output logic [IDXW-1:0]   tgt_q,
    output logic              pin_q
);
    reg_sel_e  sel;
    logic      wr_ctrl, wr_trig, wr_tgt, host_clr;
    ctrl_t     ctrl_nxt;
    logic      pend_nxt;

    assign sel      = reg_sel_e'(cpu_addr);
    assign wr_ctrl  = cpu_wr && sel == REG_CTRL;
    assign wr_trig  = cpu_wr && sel == REG_TRIG;
    assign wr_tgt   = cpu_wr && sel == REG_TGT;
    assign host_clr = evt.done && evt.data_reg && evt.idx_match;

    always_comb begin
        ctrl_nxt = wr_ctrl ? ctrl_t'(cpu_wdata[1:0]) : ctrl_q;
        pend_nxt = pend_q;
        if (host_clr) pend_nxt = 1'b0;
        if (wr_ctrl && (ctrl_nxt.pol || ctrl_nxt.mode == MODE_RSVD)) pend_nxt = 1'b0;
        // a trigger on the same edge as a host clear wins
        if (wr_trig && cpu_wdata[0] && ctrl_nxt.mode == MODE_ACCESS) pend_nxt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{mode: MODE_ACCESS, pol: 1'b0};
            pend_q <= 1'b0;
            tgt_q  <= '0;
            pin_q  <= 1'b1;
        end else begin
            ctrl_q <= ctrl_nxt;
            pend_q <= pend_nxt;
            if (wr_tgt) tgt_q <= cpu_wdata[IDXW-1:0];
            pin_q  <= pin_level(pend_nxt, ctrl_nxt);
        end
    end

    always_comb begin
        cpu_rdata = '0;
        unique case (sel)
            REG_CTRL: cpu_rdata[1:0]      = ctrl_q;
            REG_TRIG: cpu_rdata[0]        = pend_q;
            REG_TGT:  cpu_rdata[IDXW-1:0] = tgt_q;
            REG_NONE: cpu_rdata           = '0;
        endcase
    end
endmodule

// File: rtl/hdrq_top.sv
module hdrq_top
    import hdrq_pkg::*;
#(
    parameter int DW     = 8,
    parameter int IDXW   = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [DW-1:0]     cpu_rdata,
    input  logic              host_cs_n,
    input  logic              host_rs,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [IDXW-1:0]   host_idx,
    output logic              dreq_pin
);
    localparam int DATW = IDXW + 1;

    logic [2:0]      strb_s;
    logic [DATW-1:0] dat_s;
    host_evt_t       evt_w;
    ctrl_t           ctrl_w;
    logic            pend_w;
    logic [IDXW-1:0] tgt_w;

    hdrq_sync #(.W(3), .STAGES(STAGES), .RST_VAL(3'b111)) u_sync_strb (
        .clk (clk),
        .rst (rst),
        .d   ({host_cs_n, host_rd_n, host_wr_n}),
        .q   (strb_s)
    );

    hdrq_sync #(.W(DATW), .STAGES(STAGES), .RST_VAL('0)) u_sync_dat (
        .clk (clk),
        .rst (rst),
        .d   ({host_rs, host_idx}),
        .q   (dat_s)
    );

    hdrq_host_det #(.IDXW(IDXW)) u_det (
        .clk     (clk),
        .rst     (rst),
        .cs_n_s  (strb_s[2]),
        .rs_s    (dat_s[DATW-1]),
        .rd_n_s  (strb_s[1]),
        .wr_n_s  (strb_s[0]),
        .idx_s   (dat_s[IDXW-1:0]),
        .tgt_idx (tgt_w),
        .evt     (evt_w)
    );

    hdrq_core #(.DW(DW), .IDXW(IDXW)) u_core (
        .clk       (clk),
        .rst       (rst),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .evt       (evt_w),
        .ctrl_q    (ctrl_w),
        .pend_q    (pend_w),
        .tgt_q     (tgt_w),
        .pin_q     (dreq_pin)
    );
endmodule

// File: rtl/hdrq_chk.sv
module hdrq_chk
    import hdrq_pkg::*;
#(
    parameter int DW = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_wr,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic [DW-1:0]     cpu_wdata,
    input logic              dreq_pin,
    input logic              pend,
    input logic              pol,
    input logic              mode,
    input logic              done,
    input logic              data_reg,
    input logic              idx_match
);
    // R2
    r2_trig_assert_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == 2'd1 && cpu_wdata[0] && !mode) |=> (pend && dreq_pin == pol));

    // R3
    r3_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && !(done && data_reg && idx_match) && !cpu_wr) |=> (pend && dreq_pin == pol));

    // R4
    r4_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (done && data_reg && idx_match && !cpu_wr) |=> (!pend && dreq_pin != pol));

    // R5
    r5_index_write_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !data_reg && !cpu_wr) |=> $stable(pend));

    // R7
    r7_pol_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == 2'd0 && cpu_wdata[0]) |=> (!pend && !dreq_pin));

    // R8
    r8_reserved_chk: assert property (@(posedge clk) disable iff (rst)
        mode |-> (!pend && dreq_pin != pol));
endmodule

bind hdrq_top hdrq_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .dreq_pin  (dreq_pin),
    .pend      (pend_w),
    .pol       (ctrl_w.pol),
    .mode      (ctrl_w.mode),
    .done      (evt_w.done),
    .data_reg  (evt_w.data_reg),
    .idx_match (evt_w.idx_match)
);

// File: tb/tb_hdrq_top.sv
module tb_hdrq_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_wr = 1'b0;
    logic [1:0] cpu_addr = 2'd0;
    logic [7:0] cpu_wdata = 8'd0;
    logic [7:0] cpu_rdata;
    logic       host_cs_n = 1'b1, host_rs = 1'b0, host_rd_n = 1'b1, host_wr_n = 1'b1;
    logic [7:0] host_idx = 8'd0;
    logic       dreq_pin;
    int         n_chk = 0;
    int         n_err = 0;

    always #5 clk = ~clk;

    hdrq_top dut (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .host_cs_n(host_cs_n),
        .host_rs(host_rs), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_idx(host_idx), .dreq_pin(dreq_pin)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cpu_wr = 1'b0; cpu_wdata = 8'd0;
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        #1 d = cpu_rdata;
    endtask

    // one host access; ends at the negedge on which the strobe is released
    task automatic host_access(input logic cs, input logic rs, input logic [7:0] idx,
                               input logic is_wr);
        @(negedge clk);
        host_cs_n = ~cs; host_rs = rs; host_idx = idx;
        if (is_wr) host_wr_n = 1'b0; else host_rd_n = 1'b0;
        repeat (4) @(negedge clk);
        host_cs_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1;
        host_rs = 1'b0; host_idx = 8'd0;
    endtask

    // watch the pin after a release: cleared on the third rising edge, or held
    task automatic watch_release(input string req, input logic clears, input logic asserted);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk({req, " before edge 3"}, {7'd0, dreq_pin}, {7'd0, asserted});
        @(posedge clk);
        @(negedge clk);
        chk({req, " at edge 3"}, {7'd0, dreq_pin}, {7'd0, clears ? ~asserted : asserted});
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk({req, " settled"}, {7'd0, dreq_pin}, {7'd0, clears ? ~asserted : asserted});
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 pin", {7'd0, dreq_pin}, 8'd1);
        cpu_read(2'd0, d); chk("R1 ctrl", d, 8'd0);
        cpu_read(2'd1, d); chk("R1 pending", d, 8'd0);
        cpu_read(2'd2, d); chk("R1 target", d, 8'd0);
        cpu_read(2'd3, d); chk("R9 spare addr", d, 8'd0);
    endtask

    task automatic t_basic();
        logic [7:0] d;
        cpu_write(2'd2, 8'h05);
        cpu_read(2'd2, d); chk("R9 target readback", d, 8'h05);
        cpu_write(2'd1, 8'h01);
        chk("R2 pin asserted low", {7'd0, dreq_pin}, 8'd0);
        cpu_read(2'd1, d); chk("R2 pending bit", d, 8'd1);
        cpu_write(2'd1, 8'h00);
        chk("R3 zero write no effect", {7'd0, dreq_pin}, 8'd0);
        cpu_write(2'd1, 8'h01);
        chk("R3 retrigger keeps asserted", {7'd0, dreq_pin}, 8'd0);
        host_access(1'b1, 1'b1, 8'h05, 1'b1);
        watch_release("R4 data write clears", 1'b1, 1'b0);
        cpu_read(2'd1, d); chk("R4 pending cleared", d, 8'd0);
        host_access(1'b1, 1'b1, 8'h05, 1'b0);
        watch_release("R3 nothing queued", 1'b0, 1'b1);
    endtask

    task automatic t_index_write();
        cpu_write(2'd1, 8'h01);
        host_access(1'b1, 1'b0, 8'h05, 1'b1);
        watch_release("R5 index write ignored", 1'b0, 1'b0);
        host_access(1'b1, 1'b1, 8'h05, 1'b0);
        watch_release("R4 data read clears", 1'b1, 1'b0);
    endtask

    task automatic t_mismatch();
        cpu_write(2'd1, 8'h01);
        host_access(1'b1, 1'b1, 8'h03, 1'b1);
        watch_release("R6 wrong index ignored", 1'b0, 1'b0);
        host_access(1'b0, 1'b1, 8'h05, 1'b1);
        watch_release("R6 no chip select ignored", 1'b0, 1'b0);
        host_access(1'b1, 1'b1, 8'h05, 1'b1);
        watch_release("R4 cleanup clear", 1'b1, 1'b0);
    endtask

    task automatic t_polarity();
        logic [7:0] d;
        cpu_write(2'd1, 8'h01);
        chk("R2 pending before pol", {7'd0, dreq_pin}, 8'd0);
        cpu_write(2'd0, 8'h01);
        chk("R7 pol write drives low", {7'd0, dreq_pin}, 8'd0);
        cpu_read(2'd1, d); chk("R7 pol write clears pending", d, 8'd0);
        cpu_read(2'd0, d); chk("R9 ctrl readback", d, 8'h01);
        cpu_write(2'd1, 8'h01);
        chk("R7 active-high assert", {7'd0, dreq_pin}, 8'd1);
        host_access(1'b1, 1'b1, 8'h05, 1'b1);
        watch_release("R7 active-high clear", 1'b1, 1'b1);
        cpu_write(2'd0, 8'h00);
        chk("R7 back to active-low idle", {7'd0, dreq_pin}, 8'd1);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        cpu_write(2'd1, 8'h01);
        cpu_write(2'd0, 8'h02);
        chk("R8 reserved forces idle", {7'd0, dreq_pin}, 8'd1);
        cpu_read(2'd1, d); chk("R8 reserved clears pending", d, 8'd0);
        cpu_write(2'd1, 8'h01);
        chk("R8 trigger ignored pin", {7'd0, dreq_pin}, 8'd1);
        cpu_read(2'd1, d); chk("R8 trigger ignored pending", d, 8'd0);
        cpu_read(2'd0, d); chk("R9 mode readback", d, 8'h02);
        cpu_write(2'd0, 8'h00);
        chk("R8 leaving reserved stays idle", {7'd0, dreq_pin}, 8'd1);
        cpu_write(2'd1, 8'h01);
        chk("R2 trigger after reserved", {7'd0, dreq_pin}, 8'd0);
        host_access(1'b1, 1'b1, 8'h05, 1'b0);
        watch_release("R4 final clear", 1'b1, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_index_write();
        t_mismatch();
        t_polarity();
        t_reserved();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule